// File: doc/BRIEF.md
# Flash Command Launch Controller

This block is the register-side front end of an embedded flash controller. Software reaches it through a small synchronous register port with four addresses: a status word, a clock divider, a parameter index and a parameter window. The divider turns the bus clock into a slow time-base tick, with a 1 MHz target, that drives the erase and program timing in the back end. The parameter window reaches one word of a bank of command parameter words at a time. The index register picks that word.

Software loads the parameter words and then writes 1 to the command-complete bit of the status word. The block checks the command first. If it is allowed, the complete bit drops and the block sends a one-cycle start pulse to an execution engine, with the whole parameter bank attached. When the engine returns its done pulse, the result words replace the parameters and the complete bit rises again. A refused launch sets the access-error flag instead.

While a command is running, the block ignores writes to the parameter words, the index and the divider, so the engine sees a frozen configuration.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset the status word reads 0x0001 (complete bit 0 set, access-error bit 1 and protection bit 2 clear). The divider register, the index register and every parameter word read 0.
- R2: A write to the divider register (address 1) stores `reg_wdata[DIV_W-1:0]` and sets the read-only loaded bit, which reads as bit `DATA_W-1` of address 1. Once set, the loaded bit stays set until reset.
- R3: Before the divider has been written, `tb_tick` stays low. After a write of value D, `tb_tick` is a one-cycle pulse that repeats every D+1 clocks.
- R4: Address 2 holds the index `reg_wdata[IDX_W-1:0]`. Accesses to address 3 reach the parameter word that the index selects. An index of `NWORDS` or above reads 0, and a write through it changes no word.
- R5: Writing the status word (address 0) with bit 0 set launches the command when all three hold: the complete bit is 1, both error flags are 0, and the time-base rule of R6 allows it. A launch clears the complete bit at that edge. In the next cycle `eng_start` is high for exactly one cycle, and `eng_params` carries word i in bits [i*DATA_W +: DATA_W].
- R6: A command whose word 0 has bit `DATA_W-1` set needs the time base. If the divider is not loaded, such a launch request starts nothing, sets access-error bit 1 and leaves the complete bit at 1. A command with that bit clear may launch without a loaded divider.
- R7: While either error flag is set, a launch request starts nothing and changes no flag. Writing 1 to status bit 1 clears the access-error flag, and writing 1 to bit 2 clears the protection flag.
- R8: The complete bit stays 0 until `eng_done` is seen. At that edge it returns to 1, and the parameter words take the values on `eng_results`.
- R9: While the complete bit is 0, writes to the parameter window, the index and the divider have no effect, and a further launch request starts nothing.
- R10: If `eng_prot_err` is high together with `eng_done` while a command runs, status bit 2 is set when the command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 divider, 2 index, 3 parameter window) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| tb_tick | output | 1 | Time-base tick pulse |
| eng_start | output | 1 | One-cycle command start to the engine |
| eng_params | output | NWORDS*DATA_W | Parameter words to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_prot_err | input | 1 | Protection violation, qualified by `eng_done` |
| eng_results | input | NWORDS*DATA_W | Result words, qualified by `eng_done` |

## Verification
The hardest case to reach is a write that arrives during the short window while a command is running. That window only lasts as long as the stub engine is busy, so the bench makes the stub wait four time-base ticks with a divider of 4. Inside that window it issues writes to the parameter window, index and divider plus a second launch request, then reads the frozen values back once the command completes. The access-error and protection paths need their flags set from the ports: the first comes from a time-base command launched before any divider write, and the second from a command code that tells the stub to report a protection error.

// File: rtl/fcf_pkg.sv
`timescale 1ns/1ps
package fcf_pkg;
   typedef enum logic [1:0] {
      A_STAT = 2'd0,
      A_CDIV = 2'd1,
      A_INDX = 2'd2,
      A_PARM = 2'd3
   } fcf_addr_e;

   localparam int ST_DONE = 0;
   localparam int ST_ACCE = 1;
   localparam int ST_PVIO = 2;
endpackage

// File: rtl/fcf_timebase.sv
`timescale 1ns/1ps
module fcf_timebase #(
   parameter int DIV_W    = 8,
   parameter bit TICK_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [DIV_W-1:0] ld_val,
   output logic [DIV_W-1:0] div_val,
   output logic             loaded,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic             hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_val <= '0;
         cnt     <= '0;
         loaded  <= 1'b0;
      end else if (ld) begin
         div_val <= ld_val;
         cnt     <= ld_val;
         loaded  <= 1'b1;
      end else if (loaded) begin
         cnt <= (cnt == '0) ? div_val : cnt - 1'b1;
      end
   end

   assign hit = loaded && (cnt == '0);

   generate
      if (TICK_REG) begin : g_tick_reg
         logic tick_q;
         always_ff @(posedge clk) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= hit;
         end
         assign tick = tick_q;
      end else begin : g_tick_comb
         assign tick = hit;
      end
   endgenerate
endmodule

// File: rtl/fcf_param_bank.sv
`timescale 1ns/1ps
module fcf_param_bank #(
   parameter int DATA_W = 16,
   parameter int NWORDS = 6,
   parameter int IDX_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     idx_we,
   input  logic [IDX_W-1:0]         idx_wval,
   input  logic                     word_we,
   input  logic [DATA_W-1:0]        word_wval,
   input  logic                     res_load,
   input  logic [NWORDS*DATA_W-1:0] res_words,
   output logic [IDX_W-1:0]         idx,
   output logic [DATA_W-1:0]        rd_word,
   output logic [NWORDS*DATA_W-1:0] words
);
   logic [DATA_W-1:0] word_q [NWORDS];

   always_ff @(posedge clk) begin
      if (!rst_n)      idx <= '0;
      else if (idx_we) idx <= idx_wval;
   end

   generate
      for (genvar i = 0; i < NWORDS; i++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n)
               word_q[i] <= '0;
            else if (res_load)
               word_q[i] <= res_words[i*DATA_W +: DATA_W];
            else if (word_we && idx == IDX_W'(i))
               word_q[i] <= word_wval;
         end
         assign words[i*DATA_W +: DATA_W] = word_q[i];
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NWORDS; i++)
         if (idx == IDX_W'(i)) rd_word = word_q[i];
   end
endmodule

// File: rtl/fcf_sequencer.sv
`timescale 1ns/1ps
module fcf_sequencer (
   input  logic clk,
   input  logic rst_n,
   input  logic stat_we,
   input  logic w_done,
   input  logic w_acc,
   input  logic w_pv,
   input  logic div_loaded,
   input  logic needs_tb,
   input  logic eng_done,
   input  logic eng_prot_err,
   output logic ccif,
   output logic accerr,
   output logic pverr,
   output logic start,
   output logic res_load
);
   logic launch_req, blocked, launch_ok, acc_set;

   assign launch_req = stat_we && w_done && ccif;
   assign blocked    = accerr || pverr;
   assign launch_ok  = launch_req && !blocked && (div_loaded || !needs_tb);
   assign acc_set    = launch_req && !blocked && !div_loaded && needs_tb;
   assign res_load   = !ccif && eng_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ccif   <= 1'b1;
         accerr <= 1'b0;
         pverr  <= 1'b0;
         start  <= 1'b0;
      end else begin
         start <= launch_ok;
         if (launch_ok)     ccif <= 1'b0;
         else if (res_load) ccif <= 1'b1;
         if (acc_set)                accerr <= 1'b1;
         else if (stat_we && w_acc)  accerr <= 1'b0;
         if (res_load && eng_prot_err) pverr <= 1'b1;
         else if (stat_we && w_pv)     pverr <= 1'b0;
      end
   end
endmodule

// File: rtl/flash_cmd_front.sv
`timescale 1ns/1ps
module flash_cmd_front #(
   parameter int DATA_W   = 16,
   parameter int NWORDS   = 6,
   parameter int DIV_W    = 8,
   parameter bit TICK_REG = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_we,
   input  logic [1:0]               reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   output logic                     tb_tick,
   output logic                     eng_start,
   output logic [NWORDS*DATA_W-1:0] eng_params,
   input  logic                     eng_done,
   input  logic                     eng_prot_err,
   input  logic [NWORDS*DATA_W-1:0] eng_results
);
   import fcf_pkg::*;

   localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

   initial begin
      assert (DATA_W >= 8) else $error("DATA_W must be at least 8");
      assert (DIV_W < DATA_W) else $error("DIV_W must leave room for the loaded bit");
      assert (NWORDS >= 2) else $error("NWORDS must be at least 2");
   end

   logic ccif, accerr, pverr, div_loaded, res_load;
   logic cfg_we, stat_we, div_we, idx_we, word_we;
   logic [DIV_W-1:0]  div_val;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] rd_word;

   assign cfg_we  = reg_we && ccif;
   assign stat_we = reg_we && (reg_addr == A_STAT);
   assign div_we  = cfg_we && (reg_addr == A_CDIV);
   assign idx_we  = cfg_we && (reg_addr == A_INDX);
   assign word_we = cfg_we && (reg_addr == A_PARM);

   fcf_timebase #(.DIV_W(DIV_W), .TICK_REG(TICK_REG)) i_tb (
      .clk(clk), .rst_n(rst_n), .ld(div_we), .ld_val(reg_wdata[DIV_W-1:0]),
      .div_val(div_val), .loaded(div_loaded), .tick(tb_tick));

   fcf_param_bank #(.DATA_W(DATA_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) i_bank (
      .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wval(reg_wdata[IDX_W-1:0]),
      .word_we(word_we), .word_wval(reg_wdata), .res_load(res_load),
      .res_words(eng_results), .idx(idx), .rd_word(rd_word), .words(eng_params));

   fcf_sequencer i_seq (
      .clk(clk), .rst_n(rst_n), .stat_we(stat_we),
      .w_done(reg_wdata[ST_DONE]), .w_acc(reg_wdata[ST_ACCE]), .w_pv(reg_wdata[ST_PVIO]),
      .div_loaded(div_loaded), .needs_tb(eng_params[DATA_W-1]),
      .eng_done(eng_done), .eng_prot_err(eng_prot_err),
      .ccif(ccif), .accerr(accerr), .pverr(pverr), .start(eng_start), .res_load(res_load));

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_STAT: begin
            reg_rdata[ST_DONE] = ccif;
            reg_rdata[ST_ACCE] = accerr;
            reg_rdata[ST_PVIO] = pverr;
         end
         A_CDIV: begin
            reg_rdata[DIV_W-1:0]  = div_val;
            reg_rdata[DATA_W-1]   = div_loaded;
         end
         A_INDX: reg_rdata[IDX_W-1:0] = idx;
         default: reg_rdata = rd_word;
      endcase
   end
endmodule

// File: rtl/fcf_chk.sv
`timescale 1ns/1ps
module fcf_chk #(
   parameter int PW = 96
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ccif,
   input logic          accerr,
   input logic          pverr,
   input logic          div_loaded,
   input logic          tick,
   input logic          eng_start,
   input logic          eng_done,
   input logic [PW-1:0] eng_params
);
   // R5
   start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (!ccif && $past(ccif) && !$past(accerr) && !$past(pverr)));
   // R5
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   // R2
   loaded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_loaded |=> div_loaded);
   // R3
   tick_needs_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> div_loaded);
   // R9
   params_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ccif && !eng_done) |=> $stable(eng_params));
   // R8
   done_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ccif && eng_done) |=> ccif);
   // R7
   err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accerr || pverr) |=> !eng_start);
endmodule

bind flash_cmd_front fcf_chk #(.PW(NWORDS*DATA_W)) i_fcf_chk (
   .clk(clk), .rst_n(rst_n), .ccif(ccif), .accerr(accerr), .pverr(pverr),
   .div_loaded(div_loaded), .tick(tb_tick), .eng_start(eng_start),
   .eng_done(eng_done), .eng_params(eng_params));

// File: tb/test_flash_cmd_front.sv
`timescale 1ns/1ps
module test_flash_cmd_front;
   localparam int DW  = 16;
   localparam int NW  = 6;
   localparam int LAT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic tb_tick, eng_start;
   logic [NW*DW-1:0] eng_params;
   logic eng_done = 1'b0;
   logic eng_prot_err = 1'b0;
   logic [NW*DW-1:0] eng_results = '0;

   int checks = 0;
   int errors = 0;
   int starts = 0;

   always #2.5 clk = ~clk;

   flash_cmd_front #(.DATA_W(DW), .NWORDS(NW)) i_flash_cmd_front (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tb_tick(tb_tick),
      .eng_start(eng_start), .eng_params(eng_params), .eng_done(eng_done),
      .eng_prot_err(eng_prot_err), .eng_results(eng_results));

   // stub engine: results are parameters plus one; low byte EE of word 0 reports protection
   initial begin
      logic [NW*DW-1:0] cap;
      forever begin
         @(negedge clk);
         if (eng_start) begin
            starts++;
            cap = eng_params;
            for (int n = 0; n < LAT; n++) begin
               if (cap[DW-1]) begin
                  do @(negedge clk); while (!tb_tick);
               end else begin
                  repeat (3) @(negedge clk);
               end
            end
            for (int i = 0; i < NW; i++)
               eng_results[i*DW +: DW] = cap[i*DW +: DW] + 16'd1;
            eng_prot_err = (cap[7:0] == 8'hEE);
            eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
            eng_prot_err = 1'b0;
         end
      end
   end

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_done();
      logic [DW-1:0] s;
      for (int k = 0; k < 2000; k++) begin
         rd(2'd0, s);
         if (s[0]) break;
      end
   endtask

   localparam logic [31:0] VEC [4] = '{
      {16'h8010, 16'h1234},
      {16'h8020, 16'hFFFF},
      {16'h0030, 16'h00AA},
      {16'h80FF, 16'h7FFF}
   };

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] v;
      int ticks, gap, s0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, v); chk("R1 status", v, 16'h0001);
      rd(2'd1, v); chk("R1 divider", v, 16'h0000);
      rd(2'd2, v); chk("R1 index", v, 16'h0000);
      rd(2'd3, v); chk("R1 word0", v, 16'h0000);

      // R3 no tick before divider load
      ticks = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (tb_tick) ticks++; end
      chk("R3 no tick unloaded", 16'(ticks), 16'd0);

      // R6 time-base command without divider
      wr(2'd3, 16'h8021);
      wr(2'd0, 16'h0001);
      repeat (3) @(negedge clk);
      rd(2'd0, v); chk("R6 access error", v, 16'h0003);
      chk("R6 no start", 16'(starts), 16'd0);

      // R7 error blocks launch, W1C clears
      wr(2'd3, 16'h0021);
      wr(2'd0, 16'h0001);
      repeat (3) @(negedge clk);
      rd(2'd0, v); chk("R7 blocked flags", v, 16'h0003);
      chk("R7 no start", 16'(starts), 16'd0);
      wr(2'd0, 16'h0002);
      rd(2'd0, v); chk("R7 w1c", v, 16'h0001);

      // R6 plain command launches without divider
      wr(2'd0, 16'h0001);
      wait_done();
      chk("R6 plain start", 16'(starts), 16'd1);
      rd(2'd3, v); chk("R8 result plain", v, 16'h0022);

      // R2 divider write
      wr(2'd1, 16'h0004);
      rd(2'd1, v); chk("R2 divider loaded", v, 16'h8004);

      // R3 tick period
      do @(negedge clk); while (!tb_tick);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!tb_tick);
      chk("R3 tick period", 16'(gap), 16'd5);

      // R5 R8 table of commands
      foreach (VEC[n]) begin
         s0 = starts;
         wr(2'd2, 16'd0); wr(2'd3, VEC[n][31:16]);
         wr(2'd2, 16'd1); wr(2'd3, VEC[n][15:0]);
         wr(2'd0, 16'h0001);
         rd(2'd0, v); chk("R8 busy", v, 16'h0000);
         wait_done();
         chk("R5 one start", 16'(starts - s0), 16'd1);
         wr(2'd2, 16'd0); rd(2'd3, v); chk("R8 result w0", v, VEC[n][31:16] + 16'd1);
         wr(2'd2, 16'd1); rd(2'd3, v); chk("R8 result w1", v, VEC[n][15:0] + 16'd1);
         rd(2'd0, v); chk("R5 status idle", v, 16'h0001);
      end

      // R9 writes ignored while busy
      wr(2'd2, 16'd0); wr(2'd3, 16'h8100);
      s0 = starts;
      wr(2'd0, 16'h0001);
      wr(2'd2, 16'd2); wr(2'd3, 16'h5555); wr(2'd1, 16'h0009); wr(2'd0, 16'h0001);
      rd(2'd0, v); chk("R9 still busy", v, 16'h0000);
      wait_done();
      chk("R9 single start", 16'(starts - s0), 16'd1);
      rd(2'd2, v); chk("R9 index kept", v, 16'h0000);
      rd(2'd1, v); chk("R9 divider kept", v, 16'h8004);
      rd(2'd3, v); chk("R9 word kept", v, 16'h8101);

      // R10 protection flag
      wr(2'd3, 16'h80EE);
      wr(2'd0, 16'h0001);
      wait_done();
      rd(2'd0, v); chk("R10 prot flag", v, 16'h0005);
      s0 = starts;
      wr(2'd0, 16'h0001);
      repeat (3) @(negedge clk);
      chk("R7 prot blocks", 16'(starts - s0), 16'd0);
      rd(2'd0, v); chk("R7 prot kept", v, 16'h0005);
      wr(2'd0, 16'h0004);
      rd(2'd0, v); chk("R7 prot w1c", v, 16'h0001);

      // R4 index window and out-of-range index
      wr(2'd2, 16'd5); wr(2'd3, 16'h0BAD);
      wr(2'd2, 16'd7); wr(2'd3, 16'h1234);
      rd(2'd3, v); chk("R4 out of range reads 0", v, 16'h0000);
      rd(2'd2, v); chk("R4 index readback", v, 16'h0007);
      wr(2'd2, 16'd5);
      rd(2'd3, v); chk("R4 word5 kept", v, 16'h0BAD);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule